// File: doc/BRIEF.md
# Modulo Timebase with Race-Safe Overflow Flag

This block is a timebase for a small microcontroller-style bus. A 16-bit up-counter advances by one on every clock while it runs. When the count equals a programmable modulo value, the next edge returns the count to zero and latches an overflow flag. Software can route that flag to an interrupt request line.

The flag has no single-write clear. Software first reads the control/status register while the flag is set, which arms a clear. It then writes a zero to the flag bit. If the counter wraps again at any point between those two accesses, the clear is cancelled and the flag stays set. A second overflow therefore never disappears behind the acknowledgement of the first one.

Three registers are visible: control/status at address 0, modulo at address 1 and a read-only count at address 2.

Top module: `modulo_timebase`

## Requirements
- R1: After reset the count is 0 and the modulo register is 0xFFFF. While the counter runs, the count rises by one per clock.
- R2: While the counter runs with count equal to modulo, the next edge sets the count to 0 and sets the flag. The flag is status bit 0: 1 means the modulo value was reached, 0 means it was not.
- R3: A read of status (address 0) while the flag is 1 arms a clear. A later status write with bit 0 = 0 then clears the flag.
- R4: A status write with bit 0 = 0 and no arming read leaves the flag at 1. Any status write drops the armed state.
- R5: A wrap between the arming read and the clearing write cancels the clear, and the flag stays 1.
- R6: A wrap on the same edge as an armed clearing write keeps the flag at 1.
- R7: Writing 1 to status bit 0 leaves the flag unchanged.
- R8: Output irq equals the flag ANDed with status bit 1, the interrupt enable.
- R9: Status bit 2 = 1 stops the counter, so the count holds its value.
- R10: Writing 1 to status bit 3 sets the count to 0. Bit 3 always reads 0.
- R11: A write to the modulo register (address 1) sets the count to 0. Modulo reads back at address 1 and the count at address 2.
- R12: Reset clears the flag, the enable and the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 status/control, 1 modulo, 2 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume the bus inputs are known values after reset and that each strobe cycle is a single access. They also assume address 3 is never used. The stimulus drives every access at the falling edge for exactly one cycle and releases the strobe afterwards. The overflow-against-clear races are placed on exact edges, which are computed from the modulo value and the cycle on which the counter was started.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_MOD  = 2'd1,
        REG_CNT  = 2'd2
    } reg_sel_e;

    localparam int unsigned BIT_FLAG = 0;
    localparam int unsigned BIT_IEN  = 1;
    localparam int unsigned BIT_STOP = 2;
    localparam int unsigned BIT_CRST = 3;

    typedef struct packed {
        logic ien;
        logic stop;
    } ctrl_t;

    typedef struct packed {
        logic rd_ctrl;
        logic wr_ctrl;
        logic wr_mod;
        logic cnt_clr;
        logic flag_wr0;
    } bus_ev_t;

    function automatic logic [3:0] ctrl_image(input ctrl_t c, input logic flag);
        logic [3:0] img;
        img           = '0;
        img[BIT_FLAG] = flag;
        img[BIT_IEN]  = c.ien;
        img[BIT_STOP] = c.stop;
        return img;
    endfunction
endpackage

// File: rtl/mtb_regs.sv
module mtb_regs
    import mtb_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic         flag,
    input  logic [W-1:0] cnt,
    output ctrl_t        ctrl,
    output logic [W-1:0] modv,
    output bus_ev_t      ev,
    output logic [W-1:0] bus_rdata
);
    logic hit_ctrl, hit_mod;

    assign hit_ctrl = bus_sel && (bus_addr == REG_CTRL);
    assign hit_mod  = bus_sel && (bus_addr == REG_MOD);

    always_comb begin
        ev          = '0;
        ev.rd_ctrl  = hit_ctrl && !bus_wr;
        ev.wr_ctrl  = hit_ctrl && bus_wr;
        ev.wr_mod   = hit_mod && bus_wr;
        ev.cnt_clr  = ev.wr_mod || (ev.wr_ctrl && bus_wdata[BIT_CRST]);
        ev.flag_wr0 = ev.wr_ctrl && !bus_wdata[BIT_FLAG];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            modv <= '1;
        end else begin
            if (ev.wr_ctrl) begin
                ctrl.ien  <= bus_wdata[BIT_IEN];
                ctrl.stop <= bus_wdata[BIT_STOP];
            end
            if (ev.wr_mod) modv <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: bus_rdata[3:0] = ctrl_image(ctrl, flag);
            REG_MOD:  bus_rdata      = modv;
            REG_CNT:  bus_rdata      = cnt;
            default:  bus_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/mtb_counter.sv
module mtb_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] modv,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = run && !clr && (cnt == modv);

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt <= '0;
        else if (wrap)    cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    // R9: a stopped counter holds its value
    a_r9_stop_holds: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cnt));
    // R2: a wrap returns the count to zero
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));
    // R11: the count never passes the modulo value
    a_r11_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= modv);
endmodule

// File: rtl/mtb_ovf_flag.sv
module mtb_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic rd_ctrl,
    input  logic wr_ctrl,
    input  logic flag_wr0,
    output logic flag
);
    logic armed;
    logic clear_ok;

    assign clear_ok = armed && flag_wr0 && !wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (wrap)          flag <= 1'b1;
            else if (clear_ok) flag <= 1'b0;

            if (wrap || wr_ctrl)        armed <= 1'b0;
            else if (rd_ctrl && flag)   armed <= 1'b1;
        end
    end

    // R2: every wrap leaves the flag set
    a_r2_wrap_sets: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);
    // R2: the flag only rises after a wrap
    a_r2_rise_needs_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(wrap));
    // R4: without an armed clear the flag cannot fall
    a_r4_no_unarmed_clear: assert property (@(posedge clk) disable iff (rst)
        (flag && !armed) |=> flag);
    // R6: a wrap beats a clearing write on the same edge
    a_r6_wrap_wins: assert property (@(posedge clk) disable iff (rst)
        (wrap && flag_wr0) |=> flag);
endmodule

// File: rtl/modulo_timebase.sv
module modulo_timebase
    import mtb_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq
);
    ctrl_t        ctrl;
    bus_ev_t      ev;
    logic [W-1:0] modv, cnt;
    logic         wrap, flag;

    mtb_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag(flag), .cnt(cnt),
        .ctrl(ctrl), .modv(modv), .ev(ev), .bus_rdata(bus_rdata)
    );

    mtb_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .run(!ctrl.stop), .clr(ev.cnt_clr),
        .modv(modv), .cnt(cnt), .wrap(wrap)
    );

    mtb_ovf_flag u_flag (
        .clk(clk), .rst(rst), .wrap(wrap), .rd_ctrl(ev.rd_ctrl),
        .wr_ctrl(ev.wr_ctrl), .flag_wr0(ev.flag_wr0), .flag(flag)
    );

    assign irq = flag && ctrl.ien;

    // R12: after reset no request is pending
    a_r12_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !irq);
endmodule

// File: tb/sim_modulo_timebase.sv
module sim_modulo_timebase;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;
    int          checks = 0, failures = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    modulo_timebase u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(2'd0, d); chk("R12 status after reset", d, 16'h0000);
        rd(2'd1, d); chk("R1 modulo reset value", d, 16'hFFFF);
        chk("R12 irq after reset", {15'd0, irq}, 16'd0);
        wr(2'd0, 16'h0005);
        rd(2'd0, d); chk("R7 write 1 to clear flag", d, 16'h0004);
    endtask

    task automatic t_wrap;
        logic [15:0] d;
        int n;
        wr(2'd1, 16'd4);
        wr(2'd0, 16'h0002);
        wait_irq(n);
        chk("R2 cycles to overflow", 16'(n), 16'd5);
        chk("R8 irq with enable", {15'd0, irq}, 16'd1);
    endtask

    task automatic t_clear;
        logic [15:0] d;
        wr(2'd0, 16'h0007);
        rd(2'd0, d); chk("R7 flag kept after writing 1", d, 16'h0007);
        wr(2'd0, 16'h0006);
        rd(2'd0, d); chk("R3 armed clear", d, 16'h0006);
        chk("R8 irq low after clear", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_unarmed;
        logic [15:0] d;
        int n;
        wr(2'd0, 16'h0002);
        wait_irq(n);
        wr(2'd0, 16'h0006);
        rd(2'd0, d); chk("R4 write 0 without arm", d, 16'h0007);
        wr(2'd0, 16'h0007);
        wr(2'd0, 16'h0006);
        rd(2'd0, d); chk("R4 arm dropped by write", d, 16'h0007);
        wr(2'd0, 16'h0006);
        rd(2'd0, d); chk("R3 clear after fresh arm", d, 16'h0006);
    endtask

    task automatic t_race_between;
        logic [15:0] d;
        int n;
        wr(2'd0, 16'h0002);
        wait_irq(n);
        rd(2'd0, d);
        idle(10);
        wr(2'd0, 16'h0006);
        rd(2'd0, d); chk("R5 overflow cancels clear", d, 16'h0007);
        rd(2'd0, d);
        wr(2'd0, 16'h0006);
        rd(2'd0, d); chk("R3 clear when stopped", d, 16'h0006);
    endtask

    task automatic t_race_same;
        logic [15:0] d;
        wr(2'd1, 16'd7);
        wr(2'd0, 16'h0003);
        idle(8);
        rd(2'd0, d); chk("R2 flag after first wrap", d, 16'h0003);
        idle(6);
        wr(2'd0, 16'h0006);
        rd(2'd0, d); chk("R6 same-edge overflow wins", d, 16'h0007);
        rd(2'd2, d); chk("R2 count zero after wrap", d, 16'd0);
    endtask

    task automatic t_count;
        logic [15:0] d, d2;
        wr(2'd0, 16'h0002);
        idle(3);
        wr(2'd0, 16'h0006);
        rd(2'd2, d); chk("R1 count steps", d, 16'd4);
        idle(5);
        rd(2'd2, d2); chk("R9 stop holds count", d2, d);
        wr(2'd1, 16'd100);
        rd(2'd2, d); chk("R11 modulo write clears count", d, 16'd0);
        rd(2'd1, d); chk("R11 modulo readback", d, 16'd100);
        wr(2'd0, 16'h0002);
        idle(4);
        wr(2'd0, 16'h000E);
        rd(2'd2, d); chk("R10 count reset bit", d, 16'd0);
        rd(2'd0, d); chk("R10 reset bit reads 0", d & 16'h0008, 16'd0);
    endtask

    task automatic t_mod_zero;
        logic [15:0] d;
        rd(2'd0, d);
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0000);
        idle(2);
        rd(2'd0, d); chk("R2 modulo zero wraps", d & 16'h0001, 16'd1);
        rd(2'd2, d); chk("R2 modulo zero count", d, 16'd0);
        chk("R8 no irq when disabled", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_reset_mid;
        logic [15:0] d;
        wr(2'd0, 16'h0002);
        rst = 1; idle(2); rst = 0;
        rd(2'd0, d); chk("R12 reset clears flag", d, 16'h0000);
        rd(2'd1, d); chk("R12 reset restores modulo", d, 16'hFFFF);
    endtask

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_wrap;
        t_clear;
        t_unarmed;
        t_race_between;
        t_race_same;
        t_count;
        t_mod_zero;
        t_reset_mid;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule